// File: doc/BRIEF.md
# Interval-Scan Acquisition Sequencer

This block paces an analog-to-digital converter that samples one channel in bursts. After a software trigger it issues a group of N conversion strobes, spaced by a programmed sample interval. It then waits for the next pulse of a periodic rate generator, and the scan period of that generator sets how often a new group may begin. The run ends once a total-sample count has been used up, even when this cuts the last group short.

All settings arrive through an 8-bit register write port. Each 16-bit count occupies a pair of byte addresses, low byte first. The rate generator also needs a mode control word and a scan period that is written as two bytes in sequence to one address. A control byte holds the interval-scan enable and the multi-channel scan enable. The converter, its sample buffer and any channel list sit outside this block. The block drives only the strobe, a busy flag and a done flag.

Top module: `scan_pacer`

## Requirements
- R1: The byte addresses are: group size (N) at 0 (low byte) and 1 (high byte); sample interval (SI) at 2 and 3; total samples (TOTAL) at 4 and 5; scan period data at 6; rate-generator mode word at 7; control at 8, where bit 0 is the interval-scan enable and bit 1 is the multi-channel scan enable.
- R2: A `sw_trig` pulse is accepted only under all of these conditions: the block is idle; control bit 0 is 1 and bit 1 is 0; the last mode word was 0x74; N, SI and TOTAL are non-zero; and the active scan period is at least 2. Call cycle 0 the cycle after the clock edge that samples an accepted trigger. In cycle 0, `busy` is 1, `done` is 0 and the first strobe is issued. A trigger that is not accepted changes no output.
- R3: Inside a group, consecutive strobes are exactly SI cycles apart. A group holds N strobes, unless the total runs out first.
- R4: Writing the mode word 0x74 arms the rate generator. Writing any other value disarms it, so triggers are refused until 0x74 is written again. Every write of the mode word resets the scan-data byte order to the low byte.
- R5: The scan period is written as its low byte and then its high byte, both to address 6. It becomes active only on the high-byte write. A low-byte write on its own leaves the active period unchanged.
- R6: The rate generator pulses in cycles k*P-1, for k = 1, 2, and so on, where P is the active scan period. A pulse that finds no group in progress starts a new group, whose first strobe comes in the following cycle. A pulse that arrives during a group, including the cycle of that group's last strobe, is ignored.
- R7: Each run issues exactly TOTAL strobes. In the cycle after the last strobe, `busy` is 0 and `done` is 1.
- R8: After the run ends, no strobe is issued until a trigger is accepted. A trigger during a run has no effect. `done` stays at 1 until a trigger is accepted.
- R9: `conv_strobe` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| sw_trig | input | 1 | Software start pulse |
| conv_strobe | output | 1 | One-cycle conversion request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |

## Verification
The assertions assume that register writes do not change N, SI, TOTAL or the scan period while a run is in progress, and that `sw_trig` lasts one cycle. The stimulus programs each configuration completely before triggering, and during a run it drives only `sw_trig`. The random cases choose their counts from small ranges so that every group, gap and final truncation fits within the run limit. Directed cases cover a period of 2 against long groups, a 16-bit period and a 16-bit group size, a lone low-byte write, a wrong mode word, an illegal control value, and a retrigger in the middle of a run.

// File: rtl/scan_pacer_pkg.sv
package scan_pacer_pkg;
   localparam logic [7:0] RATE_GEN_WORD = 8'h74;
   localparam int CTRL_INTSCAN_BIT = 0;
   localparam int CTRL_MULTI_BIT   = 1;
   localparam int N_COUNTS         = 3;

   typedef enum logic [1:0] {
      CNT_GROUP  = 2'd0,
      CNT_SPACE  = 2'd1,
      CNT_TOTAL  = 2'd2
   } count_sel_e;
endpackage

// File: rtl/scan_pacer_regs.sv
module scan_pacer_regs
   import scan_pacer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [CNT_W-1:0]  group_len,
   output logic [CNT_W-1:0]  space_len,
   output logic [CNT_W-1:0]  total_len,
   output logic [CNT_W-1:0]  scan_len,
   output logic              mode_ok,
   output logic              intscan_en,
   output logic              multi_en
);
   localparam int BYTES  = CNT_W / 8;
   localparam int PTR_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam int A_SCAN = N_COUNTS * BYTES;
   localparam int A_MODE = A_SCAN + 1;
   localparam int A_CTRL = A_SCAN + 2;

   if (CNT_W % 8 != 0 || CNT_W < 16) begin : g_bad_width
      $error("scan_pacer_regs: CNT_W must be a multiple of 8 and at least 16");
   end
   if ((1 << ADDR_W) <= A_CTRL) begin : g_bad_addr
      $error("scan_pacer_regs: ADDR_W too small for the register map");
   end

   logic [N_COUNTS-1:0][BYTES-1:0] lane_hit;
   logic [N_COUNTS-1:0][CNT_W-1:0] cnt_q;
   logic [CNT_W-9:0]               scan_hold;
   logic [CNT_W-1:0]               scan_q;
   logic [PTR_W-1:0]               scan_ptr;
   logic                           scan_hit;
   logic                           scan_last;

   for (genvar g = 0; g < N_COUNTS; g++) begin : g_cnt
      for (genvar l = 0; l < BYTES; l++) begin : g_lane
         assign lane_hit[g][l] = wr_en && (wr_addr == ADDR_W'(g * BYTES + l));
      end
   end

   assign scan_hit  = wr_en && (wr_addr == ADDR_W'(A_SCAN));
   assign scan_last = (scan_ptr == PTR_W'(BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         for (int g = 0; g < N_COUNTS; g++) begin
            for (int l = 0; l < BYTES; l++) begin
               if (lane_hit[g][l]) cnt_q[g][l*8 +: 8] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_q     <= '0;
         scan_hold  <= '0;
         scan_ptr   <= '0;
         mode_ok    <= 1'b0;
         intscan_en <= 1'b0;
         multi_en   <= 1'b0;
      end else if (wr_en) begin
         if (scan_hit) begin
            if (scan_last) begin
               scan_q   <= {wr_data, scan_hold};
               scan_ptr <= '0;
            end else begin
               scan_hold[scan_ptr*8 +: 8] <= wr_data;
               scan_ptr <= scan_ptr + 1'b1;
            end
         end else if (wr_addr == ADDR_W'(A_MODE)) begin
            mode_ok  <= (wr_data == RATE_GEN_WORD);
            scan_ptr <= '0;
         end else if (wr_addr == ADDR_W'(A_CTRL)) begin
            intscan_en <= wr_data[CTRL_INTSCAN_BIT];
            multi_en   <= wr_data[CTRL_MULTI_BIT];
         end
      end
   end

   assign group_len = cnt_q[CNT_GROUP];
   assign space_len = cnt_q[CNT_SPACE];
   assign total_len = cnt_q[CNT_TOTAL];
   assign scan_len  = scan_q;

   // R5: a byte that is not the last one never alters the active period
   a_r5_lsb_holds: assert property (@(posedge clk) disable iff (!rst_n)
      scan_hit && !scan_last |=> $stable(scan_q));
endmodule

// File: rtl/scan_pacer_rategen.sv
module scan_pacer_rategen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic             pulse
);
   logic [CNT_W-1:0] cnt_q;

   assign pulse = run && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= period;
      end else if (run) begin
         cnt_q <= (cnt_q == CNT_W'(1)) ? period : cnt_q - 1'b1;
      end
   end

   // R6: each pulse reloads the full period
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      pulse && !start |=> cnt_q == $past(period));
endmodule

// File: rtl/scan_pacer_burst.sv
module scan_pacer_burst #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             scan_pulse,
   input  logic [CNT_W-1:0] group_len,
   input  logic [CNT_W-1:0] space_len,
   input  logic [CNT_W-1:0] total_len,
   output logic             fire,
   output logic             running,
   output logic             done
);
   logic             in_group;
   logic [CNT_W-1:0] space_cnt;
   logic [CNT_W-1:0] group_left;
   logic [CNT_W-1:0] total_left;
   logic             last_total;
   logic             last_group;

   assign fire       = in_group && (space_cnt == '0);
   assign last_total = (total_left == CNT_W'(1));
   assign last_group = (group_left == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running    <= 1'b0;
         in_group   <= 1'b0;
         done       <= 1'b0;
         space_cnt  <= '0;
         group_left <= '0;
         total_left <= '0;
      end else if (start) begin
         running    <= 1'b1;
         in_group   <= 1'b1;
         done       <= 1'b0;
         space_cnt  <= '0;
         group_left <= group_len;
         total_left <= total_len;
      end else if (running) begin
         if (fire) begin
            total_left <= total_left - 1'b1;
            group_left <= group_left - 1'b1;
            space_cnt  <= space_len - 1'b1;
            if (last_total) begin
               running  <= 1'b0;
               in_group <= 1'b0;
               done     <= 1'b1;
            end else if (last_group) begin
               in_group <= 1'b0;
            end
         end else if (in_group) begin
            space_cnt <= space_cnt - 1'b1;
         end else if (scan_pulse) begin
            in_group   <= 1'b1;
            space_cnt  <= '0;
            group_left <= group_len;
         end
      end
   end

   // R7: the final strobe ends the run in the next cycle
   a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
      fire && last_total && !start |=> done && !running);
   // R8: done and an active run never coexist
   a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && running));
   // R3: strobes inside a group are separated when the interval exceeds one
   a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !last_total && !last_group && space_len != CNT_W'(1) && !start |=> !fire);
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
   import scan_pacer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              sw_trig,
   output logic              conv_strobe,
   output logic              busy,
   output logic              done
);
   logic [CNT_W-1:0] group_len, space_len, total_len, scan_len;
   logic             mode_ok, intscan_en, multi_en;
   logic             cfg_ok, start, scan_pulse;

   scan_pacer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .group_len  (group_len),
      .space_len  (space_len),
      .total_len  (total_len),
      .scan_len   (scan_len),
      .mode_ok    (mode_ok),
      .intscan_en (intscan_en),
      .multi_en   (multi_en)
   );

   assign cfg_ok = intscan_en && !multi_en && mode_ok &&
                   (group_len != '0) && (space_len != '0) &&
                   (total_len != '0) && (scan_len > CNT_W'(1));
   assign start  = sw_trig && !busy && cfg_ok;

   scan_pacer_rategen #(.CNT_W(CNT_W)) u_rategen (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .run    (busy),
      .period (scan_len),
      .pulse  (scan_pulse)
   );

   scan_pacer_burst #(.CNT_W(CNT_W)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .scan_pulse (scan_pulse),
      .group_len  (group_len),
      .space_len  (space_len),
      .total_len  (total_len),
      .fire       (conv_strobe),
      .running    (busy),
      .done       (done)
   );

   // R9: a strobe only appears during a run
   a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |-> busy);
   // R4: without the rate-generator word a trigger does not start a run
   a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      sw_trig && !busy && !mode_ok |=> !busy);
endmodule

// File: tb/scan_pacer_bench.sv
module scan_pacer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       sw_trig = 1'b0;
   logic       conv_strobe, busy, done;
   int         checks = 0;
   int         fails = 0;

   scan_pacer u_scan_pacer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sw_trig(sw_trig), .conv_strobe(conv_strobe),
      .busy(busy), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // R1: 16-bit counts little-endian at 0/1, 2/3, 4/5; scan data 6, mode 7, control 8
   task automatic cfg(input int n, input int si, input int scan, input int total);
      wr(0, n & 8'hff);     wr(1, n >> 8);
      wr(2, si & 8'hff);    wr(3, si >> 8);
      wr(4, total & 8'hff); wr(5, total >> 8);
      wr(7, 8'h74);
      wr(6, scan & 8'hff);  wr(6, scan >> 8);
      wr(8, 1);
   endtask

   // first strobe of the next group: cycle after the first pulse k*scan-1 beyond last
   function automatic int next_group(input int last, input int scan);
      return ((last + 1) / scan + 1) * scan;
   endfunction

   task automatic run(input int n, input int si, input int scan, input int total,
                      input int retrig_at);
      int exp_c = 0, idx = 0, got = 0, done_at = -1;
      bit expst;
      @(negedge clk); sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      for (int c = 0; c < 40000; c++) begin
         sw_trig = 1'b0;
         if (c == 0) chk(busy && !done, "R2 busy at cycle 0", int'(busy), 1);
         expst = (got < total) && (c == exp_c);
         if (conv_strobe || expst)
            chk(conv_strobe == expst, got >= total ? "R8 strobe after end" :
                (idx == 0 ? "R6 group start" : "R3 group spacing"), c, exp_c);
         if (conv_strobe && expst) begin
            got++;
            if (got < total) begin
               if (idx < n - 1) begin exp_c = c + si; idx++; end
               else begin exp_c = next_group(c, scan); idx = 0; end
            end else done_at = c + 1;
         end
         if (done_at >= 0 && c == done_at)
            chk(done && !busy, "R7 end flags", int'(done), 1);
         if (done_at >= 0 && c > done_at && busy)
            chk(1'b0, "R8 busy after end", 1, 0);
         if (done_at >= 0 && c == done_at + 40) break;
         if (c == retrig_at) sw_trig = 1'b1;
         @(negedge clk);
      end
      sw_trig = 1'b0;
      chk(got == total, "R7 strobe count", got, total);
   endtask

   task automatic refused(input bit done_exp, input string req);
      bit seen = 0;
      @(negedge clk); sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      for (int c = 0; c < 30; c++) begin
         if (busy || conv_strobe) seen = 1;
         @(negedge clk);
      end
      chk(!seen, req, int'(seen), 0);
      chk(done == done_exp, "R8 done held", int'(done), int'(done_exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !conv_strobe, "R9 reset idle", int'(busy | done), 0);

      cfg(3, 2, 10, 7);
      run(3, 2, 10, 7, -1);

      // R4: wrong mode word refuses the trigger
      wr(7, 8'h76);
      refused(1'b1, "R4 wrong mode word");
      wr(7, 8'h74);
      run(3, 2, 10, 7, -1);

      // R2: multi-channel scan enabled, then interval scan disabled
      wr(8, 3);
      refused(1'b1, "R2 multi enable set");
      wr(8, 0);
      refused(1'b1, "R2 interval scan off");
      wr(8, 1);

      // R5: lone low byte after a committed period of 12
      cfg(2, 1, 12, 6);
      wr(7, 8'h74);
      wr(6, 8'h05);
      run(2, 1, 12, 6, -1);

      // R1: high byte of the period (258) and of the group size (256)
      cfg(2, 3, 258, 4);
      run(2, 3, 258, 4, -1);
      cfg(256, 1, 5, 5);
      run(256, 1, 5, 5, -1);

      // R6: shortest period against long groups; R8 retrigger mid-run
      cfg(4, 3, 2, 13);
      run(4, 3, 2, 13, 9);

      // R2: zero total is refused
      cfg(2, 2, 6, 0);
      refused(1'b1, "R2 zero total");

      for (int i = 0; i < 25; i++) begin
         int n, si, scan, total;
         n = 1 + int'($urandom_range(5));
         si = 1 + int'($urandom_range(3));
         scan = 2 + int'($urandom_range(38));
         total = 1 + int'($urandom_range(29));
         cfg(n, si, scan, total);
         run(n, si, scan, total, (i % 3 == 0) ? 5 : -1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule